// File: doc/BRIEF.md
# Two-Input Modulo-4 Ones Accumulator

The block is a small synchronous Moore machine. On every clock edge it reads two data bits and counts how many of them are set: none, one or two. It adds that number to a running total that it keeps modulo 4. A single output flag is high whenever the running total is zero. The block works like a single-bit parity tracker, but it takes two bits per cycle and uses modulus 4 instead of 2.

The state register is visible on a port for debug. A parameter selects one of two state encodings. The binary encoding stores the count directly. The Gray-ordered encoding steps through 00, 01, 11, 10, so each register bit behaves like a toggle flip-flop. The choice of encoding changes only the value seen on the debug port. The flag sequence for any input stream is the same under both encodings. Reset is synchronous and active low.

Top module: `ones_acc`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the count returns to zero: `state_q` becomes 2'b00 and `zero_flag` becomes 1 after that edge.
- R2: With `bit_a` and `bit_b` both 0 at an edge, the count and `state_q` stay unchanged.
- R3: With exactly one of `bit_a` and `bit_b` set at an edge, the count advances by one, modulo 4.
- R4: With both `bit_a` and `bit_b` set at an edge, the count advances by two, modulo 4.
- R5: From count 3, one set bit wraps the count to 0 and two set bits take it to 1.
- R6: `zero_flag` is 1 exactly when the count is 0. It is a Moore output: it depends only on the registered state and never on the current inputs.
- R7: With `ENC` = ENC_BIN, `state_q` holds the count in binary (count 2 reads 2'b10).
- R8: With `ENC` = ENC_GRAY, `state_q` shows counts 0,1,2,3 as 2'b00, 2'b01, 2'b11, 2'b10. A one-count step changes exactly one bit, and a two-count step inverts both bits.
- R9: For any input and reset stream, the `zero_flag` sequence is identical under both encodings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_a | input | 1 | First data bit counted this cycle |
| bit_b | input | 1 | Second data bit counted this cycle |
| zero_flag | output | 1 | High while the running count is zero |
| state_q | output | 2 | Encoded state register, for debug |

## Verification
Both outputs come straight from the one state register, so each result is due one rising edge after the inputs that cause it. `zero_flag` has no combinational path from `bit_a` or `bit_b`. The bench changes the inputs at a falling edge and lets exactly one rising edge pass. It updates its modulo-4 reference model at that rising edge and compares both encodings at the next falling edge, before it applies the next inputs. Resets are scored the same way: the reference count is zero at the first falling edge after the low-reset edge.

// File: rtl/ones_acc_pkg.sv
// Package: shared encoding type and count<->state mapping for the
// two-input modulo-4 ones accumulator.
// Assumes: the modulus is fixed at 4, so the state is two bits wide.
package ones_acc_pkg;

    localparam int MOD_N   = 4;
    localparam int CNT_W   = $clog2(MOD_N);
    localparam int IN_N    = 2;
    localparam int POP_W   = $clog2(IN_N + 1);

    typedef enum logic {
        ENC_BIN  = 1'b0,
        ENC_GRAY = 1'b1
    } enc_e;

    typedef logic [CNT_W-1:0] state_t;

    // Map a plain count to the stored pattern for an encoding.
    function automatic state_t count_to_state(input state_t cnt, input enc_e enc);
        return (enc == ENC_GRAY) ? (cnt ^ (cnt >> 1)) : cnt;
    endfunction

    // Recover the plain count from a stored pattern.
    function automatic state_t state_to_count(input state_t st, input enc_e enc);
        state_t c;
        c[CNT_W-1] = st[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            c[i] = (enc == ENC_GRAY) ? (c[i+1] ^ st[i]) : st[i];
        end
        return c;
    endfunction

endpackage

// File: rtl/ones_acc_popcnt.sv
// Module: ones_acc_popcnt
// Counts the set bits of a small input vector.
// Assumes: IN_N is small; the result is pure combinational logic.
module ones_acc_popcnt #(
    parameter int IN_N  = 2,
    parameter int POP_W = $clog2(IN_N + 1)
) (
    input  logic [IN_N-1:0]  bits_i,
    output logic [POP_W-1:0] ones_o
);

    // Sum the input bits one by one.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < IN_N; i++) begin
            ones_o = ones_o + POP_W'(bits_i[i]);
        end
    end

endmodule

// File: rtl/ones_acc_step.sv
// Module: ones_acc_step
// Next-state logic. It advances the encoded state by 0, 1 or 2 counts.
// Binary variant: a modulo-4 adder. Gray variant: a per-bit toggle mask,
// as toggle flip-flops would need it.
// Assumes: the state is two bits wide and the step never exceeds 2.
module ones_acc_step
    import ones_acc_pkg::*;
#(
    parameter enc_e ENC = ENC_BIN
) (
    input  state_t           cur_i,
    input  logic [POP_W-1:0] ones_i,
    output state_t           nxt_o
);

    generate
        if (ENC == ENC_GRAY) begin : g_gray
            state_t tgl;
            logic   odd_cnt;

            // The parity of the Gray pattern equals the count LSB.
            always_comb odd_cnt = ^cur_i;

            // Choose the bits to flip: one step flips the low bit on an even count
            // and the high bit on an odd count; two steps flip both.
            always_comb begin
                unique case (ones_i)
                    POP_W'(0): tgl = 2'b00;
                    POP_W'(1): tgl = odd_cnt ? 2'b10 : 2'b01;
                    default:   tgl = 2'b11;
                endcase
            end

            // Apply the toggle mask.
            always_comb nxt_o = cur_i ^ tgl;
        end else begin : g_bin
            // Add the step; the wrap comes from the width.
            always_comb nxt_o = cur_i + CNT_W'(ones_i);
        end
    endgenerate

endmodule

// File: rtl/ones_acc.sv
// Module: ones_acc (top)
// Two-input modulo-4 ones accumulator. Each edge it adds the number of set
// input bits to the stored count. zero_flag is decoded from the state only.
// Assumes: inputs are synchronous to clk; rst_n is synchronous, active low.
module ones_acc
    import ones_acc_pkg::*;
#(
    parameter enc_e ENC = ENC_BIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_a,
    input  logic             bit_b,
    output logic             zero_flag,
    output logic [CNT_W-1:0] state_q
);

    localparam state_t ZERO_ST = count_to_state(state_t'(0), ENC);

    logic [POP_W-1:0] ones;
    state_t           nxt;
    state_t           st_r;

    ones_acc_popcnt #(
        .IN_N  (IN_N),
        .POP_W (POP_W)
    ) u_popcnt (
        .bits_i ({bit_b, bit_a}),
        .ones_o (ones)
    );

    ones_acc_step #(
        .ENC (ENC)
    ) u_step (
        .cur_i  (st_r),
        .ones_i (ones),
        .nxt_o  (nxt)
    );

    // State register with synchronous reset to the zero-count pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) st_r <= ZERO_ST;
        else        st_r <= nxt;
    end

    // Moore output: decoded from the registered state only.
    always_comb zero_flag = (st_r == ZERO_ST);

    // Expose the state for debug.
    always_comb state_q = st_r;

endmodule

// File: rtl/ones_acc_chk.sv
// Module: ones_acc_chk
// Property checker for ones_acc, attached to it with a bind statement.
// Assumes: it sees the same ENC as the instance it watches.
module ones_acc_chk
    import ones_acc_pkg::*;
#(
    parameter enc_e ENC = ENC_BIN
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_a,
    input logic             bit_b,
    input logic             zero_flag,
    input logic [CNT_W-1:0] state_q
);

    state_t cnt;
    always_comb cnt = state_to_count(state_q, ENC);

    a_r1_reset_zero: assert property (@(posedge clk)
        disable iff (!rst_n) $rose(rst_n) |-> (state_q == 2'b00 && zero_flag));

    a_r2_idle_hold: assert property (@(posedge clk)
        disable iff (!rst_n) (!bit_a && !bit_b) |=> $stable(state_q));

    a_r3_single_step: assert property (@(posedge clk)
        disable iff (!rst_n) (bit_a ^ bit_b) |=> (cnt == state_t'($past(cnt) + 2'd1)));

    a_r4_double_step: assert property (@(posedge clk)
        disable iff (!rst_n) (bit_a && bit_b) |=> (cnt == state_t'($past(cnt) + 2'd2)));

    a_r5_wrap: assert property (@(posedge clk)
        disable iff (!rst_n) (cnt == 2'd3 && (bit_a ^ bit_b)) |=> (cnt == 2'd0));

    a_r6_flag_set: assert property (@(posedge clk)
        disable iff (!rst_n) zero_flag |-> (cnt == 2'd0));

    a_r6_flag_clear: assert property (@(posedge clk)
        disable iff (!rst_n) !zero_flag |-> (cnt != 2'd0));

    a_r8_one_bit_move: assert property (@(posedge clk)
        disable iff (!rst_n) (ENC == ENC_GRAY && (bit_a ^ bit_b))
            |=> ($countones(state_q ^ $past(state_q)) == 1));

endmodule

bind ones_acc ones_acc_chk #(.ENC(ENC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_a     (bit_a),
    .bit_b     (bit_b),
    .zero_flag (zero_flag),
    .state_q   (state_q)
);

// File: tb/ones_acc_bench.sv
// Bench: runs one binary and one Gray instance side by side on the same
// stimulus and checks both against a modulo-4 reference count.
module ones_acc_bench;
    import ones_acc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_a = 1'b0;
    logic       bit_b = 1'b0;
    logic       flag_bin, flag_gry;
    logic [1:0] st_bin, st_gry;

    int n_cmp  = 0;
    int n_bad  = 0;
    int ref_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ones_acc #(.ENC(ENC_BIN)) u_ones_acc (
        .clk (clk), .rst_n (rst_n), .bit_a (bit_a), .bit_b (bit_b),
        .zero_flag (flag_bin), .state_q (st_bin)
    );

    ones_acc #(.ENC(ENC_GRAY)) u_ones_acc_gray (
        .clk (clk), .rst_n (rst_n), .bit_a (bit_a), .bit_b (bit_b),
        .zero_flag (flag_gry), .state_q (st_gry)
    );

    // Expected Gray pattern for a count: 0,1,2,3 -> 00,01,11,10.
    function automatic logic [1:0] gray_of(input int c);
        case (c)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (ref count %0d)", req, act, exp, ref_cnt);
        end
    endtask

    // Compare every output with the reference; called at a falling edge.
    task automatic check_all(input string req);
        check({req, " R7 binary state"}, st_bin, 2'(ref_cnt));
        check({req, " R8 gray state"}, st_gry, gray_of(ref_cnt));
        check({req, " R6 binary flag"}, {1'b0, flag_bin}, {1'b0, ref_cnt == 0});
        check({req, " R9 flag agreement"}, {1'b0, flag_gry}, {1'b0, flag_bin});
    endtask

    // One cycle: drive at a falling edge, let one rising edge pass, check.
    task automatic cycle(input logic rn, input logic a, input logic b, input string req);
        rst_n = rn; bit_a = a; bit_b = b;
        @(posedge clk);
        if (!rn) ref_cnt = 0;
        else     ref_cnt = (ref_cnt + int'(a) + int'(b)) % 4;
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        @(negedge clk);
        cycle(1'b0, 1'b1, 1'b1, "R1 reset");
        cycle(1'b1, 1'b0, 1'b0, "R2 idle at zero");
        cycle(1'b1, 1'b1, 1'b0, "R3 a only");
        cycle(1'b1, 1'b0, 1'b0, "R2 idle at one");
        cycle(1'b1, 1'b0, 1'b1, "R3 b only");
        cycle(1'b1, 1'b1, 1'b0, "R3 to three");
        cycle(1'b1, 1'b0, 1'b1, "R5 wrap single");
        cycle(1'b1, 1'b1, 1'b1, "R4 double");
        cycle(1'b1, 1'b1, 1'b0, "R3 to three again");
        cycle(1'b1, 1'b1, 1'b1, "R5 wrap double");
        cycle(1'b1, 1'b1, 1'b1, "R4 one to three");
        cycle(1'b1, 1'b0, 1'b0, "R2 hold three");
        cycle(1'b0, 1'b0, 1'b0, "R1 reset from three");
        for (int i = 0; i < N_RANDOM; i++) begin
            automatic logic rn = ($urandom_range(0, 49) != 0);
            cycle(rn, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R9 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule